// File: doc/BRIEF.md
# Warp Issue Sequencer

The sequencer keeps up to 24 resident warp contexts, each with a program counter, a 32-bit thread mask and a flag marking a pending memory access. For each warp instruction it chooses one ready warp and feeds that instruction to 8 scalar lanes over four back-to-back beats. Each beat carries the warp number, the program counter, a thread-group index and the 8 mask bits for the threads in that group.

Warps are chosen round-robin at instruction boundaries. A warp whose finished instruction touched memory sits out until a completion for it arrives. While it waits, the other warps fill the issue slots, so its latency is hidden. Divergent control flow is handled by rewriting a warp's thread mask. A warp whose mask is all zero is passed over and uses no beats. The lanes accept a beat through a ready signal and, on the final beat, report whether the instruction was a memory access.

Top module: `warp_issue_seq`

## Requirements
- R1: After reset no instruction is presented (`issue_valid` low) until a warp is launched.
- R2: Every issued instruction occupies exactly four accepted beats with `issue_group` 0, 1, 2, 3 in that order. A beat stays on the outputs unchanged for as long as `lane_ready` is low.
- R3: During beat k, bit i of `issue_lane_mask` equals bit 8k+i of the warp's 32-bit thread mask, with bit 0 = thread 0.
- R4: Warp selection is round-robin. The search starts at the warp after the one issued last, wrapping from 23 to 0, and warp 0 is searched first after reset.
- R5: `issue_warp` and `issue_pc` hold their values across all four beats of an instruction. A different warp is chosen only after the fourth beat is accepted.
- R6: When the fourth beat of an instruction is accepted, that warp's program counter increases by one. Its next instruction shows the new value.
- R7: If `lane_is_mem` is high when the fourth beat is accepted, the warp is not selected again until `mem_done_valid` names it. If no warp is eligible, `issue_valid` is low.
- R8: A warp whose thread mask is zero is never selected and uses no beats. A write on the mask port changes the mask used from the warp's next selection on.
- R9: When another warp is eligible at the moment the fourth beat is accepted, the first beat of the next instruction appears in the very next cycle.
- R10: Only warps loaded through the launch port are ever issued. A launch sets the program counter and mask and clears any pending memory wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_valid | input | 1 | Load a warp context this cycle |
| launch_warp | input | 5 | Warp number to load |
| launch_pc | input | 16 | Start program counter |
| launch_mask | input | 32 | Initial thread mask |
| mask_wr_valid | input | 1 | Replace a warp's thread mask |
| mask_wr_warp | input | 5 | Warp whose mask is replaced |
| mask_wr_mask | input | 32 | New thread mask |
| mem_done_valid | input | 1 | A memory access has completed |
| mem_done_warp | input | 5 | Warp whose access completed |
| lane_ready | input | 1 | Lanes accept the current beat |
| lane_is_mem | input | 1 | Instruction on the fourth beat was a memory access |
| issue_valid | output | 1 | A beat is presented |
| issue_warp | output | 5 | Warp being issued |
| issue_pc | output | 16 | Program counter of the instruction |
| issue_group | output | 2 | Thread group of this beat |
| issue_lane_mask | output | 8 | Per-lane thread enables for this beat |

## Verification
Corrupted beat-counter or selection state shows up at the very next accepted beat. The symptom is a group index out of order, a warp number that changes in the middle of an instruction, or a warp issued ahead of its round-robin turn. The scoreboard compares every accepted beat against an expected stream, so any such error is reported in the cycle it happens. A stale program counter or a lost memory-wait flag only shows when that warp is next issued. That can be one to several instructions later, and the mask rewrites and memory completions are timed so that those later issues are observed.

// File: rtl/warp_seq_pkg.sv
package warp_seq_pkg;
    localparam int WARPS   = 24;
    localparam int THREADS = 32;
    localparam int LANES   = 8;
    localparam int PC_W    = 16;
    localparam int BEATS   = THREADS / LANES;
    localparam int WID_W   = $clog2(WARPS);
    localparam int GRP_W   = $clog2(BEATS);

    typedef logic [WID_W-1:0]   warp_id_t;
    typedef logic [PC_W-1:0]    pc_t;
    typedef logic [THREADS-1:0] tmask_t;
    typedef logic [LANES-1:0]   lmask_t;
    typedef logic [GRP_W-1:0]   grp_t;

    typedef struct packed {
        logic   live;
        logic   parked;
        pc_t    pc;
        tmask_t mask;
    } warp_ctx_t;

    function automatic lmask_t group_slice(input tmask_t m, input grp_t g);
        return m[int'(g)*LANES +: LANES];
    endfunction
endpackage

// File: rtl/warp_ctx_file.sv
module warp_ctx_file
    import warp_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      launch_valid,
    input  warp_id_t  launch_warp,
    input  pc_t       launch_pc,
    input  tmask_t    launch_mask,
    input  logic      mask_wr_valid,
    input  warp_id_t  mask_wr_warp,
    input  tmask_t    mask_wr_mask,
    input  logic      mem_done_valid,
    input  warp_id_t  mem_done_warp,
    input  logic      retire_valid,
    input  warp_id_t  retire_warp,
    input  logic      retire_mem,
    output warp_ctx_t ctx_nxt [WARPS],
    output logic [WARPS-1:0] eligible
);
    for (genvar w = 0; w < WARPS; w++) begin : g_warp
        warp_ctx_t cur;
        warp_ctx_t nxt;

        always_comb begin
            nxt = cur;
            if (mem_done_valid && mem_done_warp == warp_id_t'(w))
                nxt.parked = 1'b0;
            if (mask_wr_valid && mask_wr_warp == warp_id_t'(w))
                nxt.mask = mask_wr_mask;
            if (retire_valid && retire_warp == warp_id_t'(w)) begin
                nxt.pc = cur.pc + pc_t'(1);
                if (retire_mem)
                    nxt.parked = 1'b1;
            end
            if (launch_valid && launch_warp == warp_id_t'(w)) begin
                nxt.live   = 1'b1;
                nxt.parked = 1'b0;
                nxt.pc     = launch_pc;
                nxt.mask   = launch_mask;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) cur <= '0;
            else     cur <= nxt;
        end

        assign ctx_nxt[w]  = nxt;
        assign eligible[w] = nxt.live & ~nxt.parked & (|nxt.mask);
    end
endmodule

// File: rtl/warp_rr_pick.sv
module warp_rr_pick
    import warp_seq_pkg::*;
(
    input  logic [WARPS-1:0] eligible,
    input  warp_id_t         last,
    output logic             found,
    output warp_id_t         pick
);
    always_comb begin
        int idx;
        found = 1'b0;
        pick  = '0;
        for (int off = 1; off <= WARPS; off++) begin
            idx = (int'(last) + off) % WARPS;
            if (!found && eligible[idx]) begin
                found = 1'b1;
                pick  = warp_id_t'(idx);
            end
        end
    end
endmodule

// File: rtl/warp_beat_gen.sv
module warp_beat_gen
    import warp_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lane_ready,
    input  logic     sel_found,
    input  warp_id_t sel_warp,
    input  pc_t      sel_pc,
    input  tmask_t   sel_mask,
    output logic     busy,
    output warp_id_t warp_q,
    output pc_t      pc_q,
    output grp_t     grp_q,
    output tmask_t   mask_q,
    output logic     retire
);
    localparam grp_t LAST_GRP = grp_t'(BEATS - 1);

    assign retire = busy && lane_ready && (grp_q == LAST_GRP);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            warp_q <= warp_id_t'(WARPS - 1);
            pc_q   <= '0;
            grp_q  <= '0;
            mask_q <= '0;
        end else if ((!busy || retire) && sel_found) begin
            busy   <= 1'b1;
            warp_q <= sel_warp;
            pc_q   <= sel_pc;
            grp_q  <= '0;
            mask_q <= sel_mask;
        end else if (retire) begin
            busy   <= 1'b0;
        end else if (busy && lane_ready) begin
            grp_q  <= grp_q + grp_t'(1);
        end
    end
endmodule

// File: rtl/warp_issue_seq.sv
module warp_issue_seq
    import warp_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch_valid,
    input  logic [WID_W-1:0]  launch_warp,
    input  logic [PC_W-1:0]   launch_pc,
    input  logic [THREADS-1:0] launch_mask,
    input  logic              mask_wr_valid,
    input  logic [WID_W-1:0]  mask_wr_warp,
    input  logic [THREADS-1:0] mask_wr_mask,
    input  logic              mem_done_valid,
    input  logic [WID_W-1:0]  mem_done_warp,
    input  logic              lane_ready,
    input  logic              lane_is_mem,
    output logic              issue_valid,
    output logic [WID_W-1:0]  issue_warp,
    output logic [PC_W-1:0]   issue_pc,
    output logic [GRP_W-1:0]  issue_group,
    output logic [LANES-1:0]  issue_lane_mask
);
    warp_ctx_t        ctx_nxt [WARPS];
    logic [WARPS-1:0] eligible;
    logic             sel_found;
    warp_id_t         sel_warp;
    logic             busy;
    logic             retire;
    warp_id_t         warp_q;
    pc_t              pc_q;
    grp_t             grp_q;
    tmask_t           mask_q;

    warp_ctx_file u_ctx (
        .clk            (clk),
        .rst            (rst),
        .launch_valid   (launch_valid),
        .launch_warp    (launch_warp),
        .launch_pc      (launch_pc),
        .launch_mask    (launch_mask),
        .mask_wr_valid  (mask_wr_valid),
        .mask_wr_warp   (mask_wr_warp),
        .mask_wr_mask   (mask_wr_mask),
        .mem_done_valid (mem_done_valid),
        .mem_done_warp  (mem_done_warp),
        .retire_valid   (retire),
        .retire_warp    (warp_q),
        .retire_mem     (lane_is_mem),
        .ctx_nxt        (ctx_nxt),
        .eligible       (eligible)
    );

    warp_rr_pick u_pick (
        .eligible (eligible),
        .last     (warp_q),
        .found    (sel_found),
        .pick     (sel_warp)
    );

    warp_beat_gen u_beat (
        .clk        (clk),
        .rst        (rst),
        .lane_ready (lane_ready),
        .sel_found  (sel_found),
        .sel_warp   (sel_warp),
        .sel_pc     (ctx_nxt[sel_warp].pc),
        .sel_mask   (ctx_nxt[sel_warp].mask),
        .busy       (busy),
        .warp_q     (warp_q),
        .pc_q       (pc_q),
        .grp_q      (grp_q),
        .mask_q     (mask_q),
        .retire     (retire)
    );

    assign issue_valid     = busy;
    assign issue_warp      = warp_q;
    assign issue_pc        = pc_q;
    assign issue_group     = grp_q;
    assign issue_lane_mask = group_slice(mask_q, grp_q);
endmodule

// File: rtl/warp_issue_seq_chk.sv
module warp_issue_seq_chk
    import warp_seq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             lane_ready,
    input logic             issue_valid,
    input logic [WID_W-1:0] issue_warp,
    input logic [PC_W-1:0]  issue_pc,
    input logic [GRP_W-1:0] issue_group
);
    AST_IDLE_OUT_OF_RESET: assert property (@(posedge clk) rst |=> !issue_valid); // R1

    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (rst)
        issue_valid && !lane_ready |=> issue_valid && $stable(issue_group) && $stable(issue_warp)); // R2

    AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (rst)
        issue_valid && lane_ready && issue_group != GRP_W'(BEATS - 1)
        |=> issue_valid && issue_group == GRP_W'($past(issue_group) + 1)); // R2

    AST_START_AT_GROUP0: assert property (@(posedge clk) disable iff (rst)
        $rose(issue_valid) |-> issue_group == '0); // R2

    AST_WARP_STEADY: assert property (@(posedge clk) disable iff (rst)
        issue_valid && !(lane_ready && issue_group == GRP_W'(BEATS - 1))
        |=> issue_warp == $past(issue_warp) && issue_pc == $past(issue_pc)); // R5
endmodule

bind warp_issue_seq warp_issue_seq_chk u_chk (.*);

// File: tb/warp_issue_seq_test.sv
module warp_issue_seq_test;
    import warp_seq_pkg::*;

    typedef struct {
        int     warp;
        int     pc;
        int     grp;
        lmask_t lm;
        string  req;
    } beat_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic launch_valid = 1'b0;
    logic [WID_W-1:0] launch_warp = '0;
    logic [PC_W-1:0] launch_pc = '0;
    logic [THREADS-1:0] launch_mask = '0;
    logic mask_wr_valid = 1'b0;
    logic [WID_W-1:0] mask_wr_warp = '0;
    logic [THREADS-1:0] mask_wr_mask = '0;
    logic mem_done_valid = 1'b0;
    logic [WID_W-1:0] mem_done_warp = '0;
    logic lane_ready = 1'b0;
    logic lane_is_mem = 1'b0;
    logic issue_valid;
    logic [WID_W-1:0] issue_warp;
    logic [PC_W-1:0] issue_pc;
    logic [GRP_W-1:0] issue_group;
    logic [LANES-1:0] issue_lane_mask;

    int runs = 0;
    int fails = 0;
    beat_t expq[$];

    always #5 clk = ~clk;

    warp_issue_seq uut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        runs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push_instr(input int w, input int pc, input tmask_t m, input string req);
        for (int g = 0; g < BEATS; g++)
            expq.push_back('{warp: w, pc: pc, grp: g, lm: m[g*LANES +: LANES], req: req});
    endtask

    task automatic launch(input int w, input int pc, input tmask_t m);
        launch_valid = 1'b1;
        launch_warp  = WID_W'(w);
        launch_pc    = PC_W'(pc);
        launch_mask  = m;
        step(1);
        launch_valid = 1'b0;
    endtask

    task automatic write_mask(input int w, input tmask_t m);
        mask_wr_valid = 1'b1;
        mask_wr_warp  = WID_W'(w);
        mask_wr_mask  = m;
        step(1);
        mask_wr_valid = 1'b0;
    endtask

    task automatic check_held(input int w, input int pc, input lmask_t lm, input string req);
        chk(issue_valid == 1'b1, req, "held valid", issue_valid, 1);
        chk(int'(issue_warp) == w, req, "held warp", issue_warp, w);
        chk(int'(issue_pc) == pc, req, "held pc", issue_pc, pc);
        chk(issue_group == '0, req, "held group", issue_group, 0);
        chk(issue_lane_mask == lm, req, "held lane mask", issue_lane_mask, lm);
    endtask

    // Monitor: every accepted beat is compared against the scoreboard head
    always @(negedge clk) begin
        if (!rst && issue_valid && lane_ready) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R10", "unexpected beat from warp", issue_warp, 0);
            end else begin
                beat_t e;
                e = expq.pop_front();
                chk(int'(issue_warp) == e.warp, e.req, "warp", issue_warp, e.warp);
                chk(int'(issue_pc) == e.pc, "R6", "pc", issue_pc, e.pc);
                chk(int'(issue_group) == e.grp, "R2", "group", issue_group, e.grp);
                chk(issue_lane_mask == e.lm, "R3", "lane mask", issue_lane_mask, e.lm);
            end
        end
    end

    initial begin
        #2_000_000;
        chk(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        chk(issue_valid == 1'b0, "R1", "valid after reset", issue_valid, 0);

        // Launch warps 0, 2 and a zero-mask warp 5, lanes stalled
        launch(0, 'h100, 32'hFFFF_FFFF);
        launch(2, 'h200, 32'hA5C3_0F81);
        launch(5, 'h500, 32'h0000_0000);
        check_held(0, 'h100, 8'hFF, "R5");
        step(2);
        check_held(0, 'h100, 8'hFF, "R2");

        // Round robin between 0 and 2 with 5 skipped (R4, R8, R9)
        push_instr(0, 'h100, 32'hFFFF_FFFF, "R4");
        push_instr(2, 'h200, 32'hA5C3_0F81, "R4");
        push_instr(0, 'h101, 32'hFFFF_FFFF, "R9");
        push_instr(2, 'h201, 32'hA5C3_0F81, "R8");
        lane_ready = 1'b1;
        step(16);
        lane_ready = 1'b0;

        // Warp 0 parks on a memory access; warp 2 runs alone (R7)
        push_instr(0, 'h102, 32'hFFFF_FFFF, "R7");
        push_instr(2, 'h202, 32'hA5C3_0F81, "R7");
        push_instr(2, 'h203, 32'hA5C3_0F81, "R7");
        push_instr(2, 'h204, 32'hA5C3_0F81, "R7");
        lane_ready  = 1'b1;
        lane_is_mem = 1'b1;
        step(4);
        lane_is_mem = 1'b0;
        step(12);
        lane_ready = 1'b0;

        mem_done_valid = 1'b1;
        mem_done_warp  = WID_W'(0);
        step(1);
        mem_done_valid = 1'b0;
        push_instr(2, 'h205, 32'hA5C3_0F81, "R7");
        push_instr(0, 'h103, 32'hFFFF_FFFF, "R7");
        push_instr(2, 'h206, 32'hA5C3_0F81, "R4");
        lane_ready = 1'b1;
        step(12);
        lane_ready = 1'b0;

        // Mask rewrites: warp 2 goes dark, warp 5 wakes up (R8)
        write_mask(2, 32'h0000_0000);
        write_mask(5, 32'h1234_8001);
        push_instr(0, 'h104, 32'hFFFF_FFFF, "R8");
        push_instr(5, 'h500, 32'h1234_8001, "R8");
        push_instr(0, 'h105, 32'hFFFF_FFFF, "R8");
        lane_ready = 1'b1;
        step(12);
        lane_ready = 1'b0;
        check_held(5, 'h501, 8'h01, "R8");

        // Both remaining warps park; nothing is left to issue (R7)
        push_instr(5, 'h501, 32'h1234_8001, "R7");
        push_instr(0, 'h106, 32'hFFFF_FFFF, "R7");
        lane_ready  = 1'b1;
        lane_is_mem = 1'b1;
        step(8);
        lane_ready  = 1'b0;
        lane_is_mem = 1'b0;
        step(1);
        chk(issue_valid == 1'b0, "R7", "valid with all warps parked", issue_valid, 0);
        chk(expq.size() == 0, "R2", "beats left unissued", expq.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule